// File: doc/BRIEF.md
# Pipeline Branch Squash Controller

This block keeps the instruction-valid flags and redirect control for a five-stage in-order pipeline. The stages are fetch, decode, execute, memory and writeback, and one register per stage advances on every clock. Each instruction is an abstract token. A token carries a class, a condition-outcome bit, a branch target and its own fetch address. The token for the current fetch address comes in through the fetch port in the same cycle.

The pipeline resolves branches at two depths. An unconditional jump is recognised in decode, so it discards the one younger instruction that is already in fetch. A conditional branch is only resolved in execute, so when it is taken it discards the two younger instructions in decode and fetch. A discarded instruction stays in the pipeline as a bubble: its valid flag is cleared and it keeps moving down the stages without ever writing memory or a register. A bubble counter records every valid instruction that is discarded. This lets the pipeline's branch penalty be measured from outside.

Top module: `pipe_squash`

## Requirements
- R1: While `rst` is high at a clock edge, all five stage valid flags clear, the fetch address goes to 0 and the bubble counter goes to 0.
- R2: Without a redirect, the fetch address rises by exactly 1 on each clock, and instructions retire in fetch-address order.
- R3: A valid token of class 2'b10 (jump) in decode raises `redirect` in that cycle, with its target on `redirectTarget`. The instruction in fetch enters decode invalid, and the bubble counter rises by 1.
- R4: The cycle after `redirect`, the fetch address equals the redirect target, and the fetch-stage valid flag is 1.
- R5: A valid token of class 2'b11 (conditional branch) in execute, with its condition bit at 1, raises `redirect` with its target. The instructions in decode and fetch are both invalidated, and the bubble counter rises by 2.
- R6: A conditional branch whose condition bit is 0 causes no redirect and no squash, and fetch continues sequentially.
- R7: When a taken conditional branch in execute and a jump in decode occur in the same cycle, the execute branch supplies the target and the jump is discarded.
- R8: A jump or branch whose valid flag is clear never raises a redirect or a squash.
- R9: `memWriteEn` is high only for a valid class 2'b01 (store) token in the memory stage. `regWriteEn` is high only for a valid class 2'b00 (ALU) token in writeback. Squashed tokens raise neither.
- R10: A squashed instruction is not removed. Its cleared valid flag moves one stage per clock until it leaves writeback, and `stageValid` shows it in bit order [0]=fetch up to [4]=writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| fetchPc | output | PC_W | Current fetch address |
| fetchCls | input | 2 | Class of the token at `fetchPc`: 00 ALU, 01 store, 10 jump, 11 conditional branch |
| fetchCond | input | 1 | Condition outcome of the token (1 = taken) |
| fetchTarget | input | PC_W | Branch target of the token |
| redirect | output | 1 | A resolving stage redirects fetch this cycle |
| redirectTarget | output | PC_W | Address that fetch loads on the next clock |
| stageValid | output | 5 | Valid flags, [0]=fetch up to [4]=writeback |
| memWriteEn | output | 1 | Memory-stage store is committed |
| regWriteEn | output | 1 | Writeback-stage register write is committed |
| retireValid | output | 1 | A valid instruction sits in writeback |
| retirePc | output | PC_W | Fetch address of the writeback instruction |
| bubbleCount | output | CNT_W | Number of valid instructions squashed since reset |

## Verification
The hardest case to reach is R7: a taken branch in execute in the same cycle as a valid jump in decode. Getting there needs a taken branch placed directly before a jump in program order, with the pipeline full. The stimulus uses exactly that layout. It also places a second jump right after another jump, so that a jump reaches decode already invalid and R8 is exercised. A scoreboard walks each program architecturally to predict the retire order, the write strobes and the running bubble count, and compares them as instructions leave writeback.

// File: rtl/squash_pkg.sv
package squash_pkg;
  localparam int STAGES = 5;

  typedef enum logic [1:0] {
    CLS_ALU    = 2'b00,
    CLS_STORE  = 2'b01,
    CLS_JUMP   = 2'b10,
    CLS_BRANCH = 2'b11
  } cls_e;

  // strobes from control to datapath
  typedef struct packed {
    logic redirect;
    logic fromEx;
    logic squashIf;
    logic squashId;
  } strobe_t;
endpackage

// File: rtl/squash_ctrl.sv
module squash_ctrl
  import squash_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ifValid,
  input  logic             idValid,
  input  cls_e             idCls,
  input  logic             exValid,
  input  cls_e             exCls,
  input  logic             exCond,
  output strobe_t          strobe,
  output logic [CNT_W-1:0] bubbleCount
);
  logic exTaken;
  logic idJump;
  logic [1:0] killed;

  assign exTaken = exValid && (exCls == CLS_BRANCH) && exCond;
  assign idJump  = idValid && (idCls == CLS_JUMP);

  always_comb begin
    strobe.redirect = exTaken || idJump;
    strobe.fromEx   = exTaken;            // execute outranks decode
    strobe.squashIf = exTaken || idJump;
    strobe.squashId = exTaken;
  end

  assign killed = {1'b0, strobe.squashIf && ifValid} + {1'b0, strobe.squashId && idValid};

  always_ff @(posedge clk) begin
    if (rst) bubbleCount <= '0;
    else     bubbleCount <= bubbleCount + CNT_W'(killed);
  end

  a_r3_jump_costs_one: assert property (@(posedge clk) disable iff (rst)
    (idValid && idCls == CLS_JUMP && !exTaken && ifValid) |=> bubbleCount == $past(bubbleCount) + CNT_W'(1));

  a_r5_branch_costs_two: assert property (@(posedge clk) disable iff (rst)
    (exValid && exCls == CLS_BRANCH && exCond && idValid && ifValid) |=> bubbleCount == $past(bubbleCount) + CNT_W'(2));

  a_r6_not_taken_quiet: assert property (@(posedge clk) disable iff (rst)
    (exValid && exCls == CLS_BRANCH && !exCond && !(idValid && idCls == CLS_JUMP)) |-> !strobe.redirect);

  a_r8_invalid_no_redirect: assert property (@(posedge clk) disable iff (rst)
    (!idValid && !exValid) |-> !strobe.redirect && !strobe.squashIf);
endmodule

// File: rtl/squash_datapath.sv
module squash_datapath
  import squash_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  strobe_t             strobe,
  input  cls_e                fetchCls,
  input  logic                fetchCond,
  input  logic [PC_W-1:0]     fetchTarget,
  output logic [PC_W-1:0]     pc,
  output logic                ifValid,
  output logic                idValid,
  output cls_e                idCls,
  output logic                exValid,
  output cls_e                exCls,
  output logic                exCond,
  output logic [PC_W-1:0]     redirectTarget,
  output logic [STAGES-1:0]   stageValid,
  output logic                memWriteEn,
  output logic                regWriteEn,
  output logic                retireValid,
  output logic [PC_W-1:0]     retirePc
);
  localparam int ID = 1;
  localparam int EX = 2;
  localparam int MEM = 3;
  localparam int WB = STAGES - 1;

  typedef struct packed {
    logic            valid;
    cls_e            cls;
    logic            cond;
    logic [PC_W-1:0] target;
    logic [PC_W-1:0] pc;
  } slot_t;

  slot_t stage [1:STAGES-1];
  slot_t fetched;

  always_comb begin
    fetched.valid  = ifValid && !strobe.squashIf;
    fetched.cls    = fetchCls;
    fetched.cond   = fetchCond;
    fetched.target = fetchTarget;
    fetched.pc     = pc;
  end

  assign redirectTarget = strobe.fromEx ? stage[EX].target : stage[ID].target;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      ifValid <= 1'b0;
      for (int i = 1; i < STAGES; i++) stage[i] <= '0;
    end else begin
      ifValid <= 1'b1;
      if (strobe.redirect) pc <= redirectTarget;
      else if (ifValid)    pc <= pc + PC_W'(1);
      stage[ID]       <= fetched;
      stage[EX]       <= stage[ID];
      stage[EX].valid <= stage[ID].valid && !strobe.squashId;
      for (int i = MEM; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign stageValid[0] = ifValid;
  for (genvar g = 1; g < STAGES; g++) begin : g_valid
    assign stageValid[g] = stage[g].valid;
  end

  assign idValid     = stage[ID].valid;
  assign idCls       = stage[ID].cls;
  assign exValid     = stage[EX].valid;
  assign exCls       = stage[EX].cls;
  assign exCond      = stage[EX].cond;
  assign memWriteEn  = stage[MEM].valid && (stage[MEM].cls == CLS_STORE);
  assign regWriteEn  = stage[WB].valid && (stage[WB].cls == CLS_ALU);
  assign retireValid = stage[WB].valid;
  assign retirePc    = stage[WB].pc;

  a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
    (ifValid && !strobe.redirect) |=> pc == $past(pc) + PC_W'(1));

  a_r4_lands_on_target: assert property (@(posedge clk) disable iff (rst)
    strobe.redirect |=> (pc == $past(redirectTarget)) && ifValid);

  a_r3_one_killed: assert property (@(posedge clk) disable iff (rst)
    (strobe.redirect && !strobe.fromEx) |=> !stage[ID].valid);

  a_r5_two_killed: assert property (@(posedge clk) disable iff (rst)
    strobe.fromEx |=> !stage[ID].valid && !stage[EX].valid);

  for (genvar g = 1; g < STAGES - 1; g++) begin : g_flow
    a_r10_bubble_flows: assert property (@(posedge clk) disable iff (rst)
      !stage[g].valid |=> !stage[g+1].valid);
  end
endmodule

// File: rtl/pipe_squash.sv
module pipe_squash
  import squash_pkg::*;
#(
  parameter int PC_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  output logic [PC_W-1:0]   fetchPc,
  input  logic [1:0]        fetchCls,
  input  logic              fetchCond,
  input  logic [PC_W-1:0]   fetchTarget,
  output logic              redirect,
  output logic [PC_W-1:0]   redirectTarget,
  output logic [4:0]        stageValid,
  output logic              memWriteEn,
  output logic              regWriteEn,
  output logic              retireValid,
  output logic [PC_W-1:0]   retirePc,
  output logic [CNT_W-1:0]  bubbleCount
);
  strobe_t strobe;
  logic ifValid, idValid, exValid, exCond;
  cls_e idCls, exCls;

  squash_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .ifValid(ifValid), .idValid(idValid), .idCls(idCls),
    .exValid(exValid), .exCls(exCls), .exCond(exCond),
    .strobe(strobe), .bubbleCount(bubbleCount)
  );

  squash_datapath #(.PC_W(PC_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .fetchCls(cls_e'(fetchCls)),
    .fetchCond(fetchCond), .fetchTarget(fetchTarget), .pc(fetchPc),
    .ifValid(ifValid), .idValid(idValid), .idCls(idCls), .exValid(exValid),
    .exCls(exCls), .exCond(exCond), .redirectTarget(redirectTarget),
    .stageValid(stageValid), .memWriteEn(memWriteEn), .regWriteEn(regWriteEn),
    .retireValid(retireValid), .retirePc(retirePc)
  );

  assign redirect = strobe.redirect;
endmodule

// File: tb/sim_pipe_squash.sv
module sim_pipe_squash;
  localparam int PC_W = 8;
  localparam int CNT_W = 16;
  localparam int M = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PC_W-1:0] fetchPc, fetchTarget, redirectTarget, retirePc;
  logic [1:0] fetchCls;
  logic fetchCond, redirect, memWriteEn, regWriteEn, retireValid;
  logic [4:0] stageValid;
  logic [CNT_W-1:0] bubbleCount;

  always #5 clk = ~clk;

  pipe_squash #(.PC_W(PC_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .fetchPc(fetchPc), .fetchCls(fetchCls), .fetchCond(fetchCond),
    .fetchTarget(fetchTarget), .redirect(redirect), .redirectTarget(redirectTarget),
    .stageValid(stageValid), .memWriteEn(memWriteEn), .regWriteEn(regWriteEn),
    .retireValid(retireValid), .retirePc(retirePc), .bubbleCount(bubbleCount)
  );

  logic [1:0]      progCls  [256];
  logic            progCond [256];
  logic [PC_W-1:0] progTgt  [256];

  always_comb begin
    fetchCls    = progCls[fetchPc];
    fetchCond   = progCond[fetchPc];
    fetchTarget = progTgt[fetchPc];
  end

  typedef struct {
    int pc;
    logic [1:0] cls;
    int cost;
    bit checkCost;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0, cycles = 0;
  bit running = 0;
  string tag;
  logic [4:0] pat [4];
  bit usePat;
  int patIdx;
  bit pendLand;
  int landTgt;
  int memAccum;

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic clearProg();
    for (int i = 0; i < 256; i++) begin
      progCls[i] = (i % 2 == 0) ? 2'b01 : 2'b00;
      progCond[i] = 1'b0;
      progTgt[i] = '0;
    end
  endtask

  task automatic setOp(int a, logic [1:0] c, logic cd, int t);
    progCls[a] = c; progCond[a] = cd; progTgt[a] = PC_W'(t);
  endtask

  // driver: walk the program architecturally and queue the retire stream
  task automatic buildExpected();
    int apc [M+2];
    logic [1:0] acls [M+2];
    int acost [M+2];
    int p = 0, c = 0;
    for (int k = 0; k < M + 2; k++) begin
      apc[k] = p; acls[k] = progCls[p];
      if (progCls[p] == 2'b10) begin c += 1; p = int'(progTgt[p]); end
      else if (progCls[p] == 2'b11 && progCond[p]) begin c += 2; p = int'(progTgt[p]); end
      else p = (p + 1) % 256;
      acost[k] = c;
    end
    q.delete();
    for (int k = 0; k < M; k++) begin
      exp_t e;
      e.pc = apc[k]; e.cls = acls[k]; e.cost = acost[k];
      e.checkCost = (acls[k+1][1] == 1'b0) && (acls[k+2][1] == 1'b0);
      q.push_back(e);
    end
  endtask

  task automatic runProgram(string t, bit withPat);
    tag = t; usePat = withPat; patIdx = 0; pendLand = 0; memAccum = 0;
    buildExpected();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    running = 1;
    for (int n = 0; n < 2000 && q.size() > 0; n++) @(posedge clk);
    @(negedge clk);
    check(q.size() == 0, "R2 retire count", q.size(), 0);
    running = 0;
  endtask

  // monitor: compare outputs away from the active edge
  always @(negedge clk) begin
    if (running && !rst) begin
      if (pendLand) begin
        check(int'(fetchPc) == landTgt && stageValid[0], "R4 landing pc", int'(fetchPc), landTgt);
        pendLand = 0;
      end
      if (patIdx > 0 && patIdx <= 4) begin
        check(stageValid == pat[patIdx-1], "R10 bubble shape", int'(stageValid), int'(pat[patIdx-1]));
        patIdx++;
      end
      if (redirect) begin
        pendLand = 1; landTgt = int'(redirectTarget);
        if (usePat && patIdx == 0) patIdx = 1;
      end
      if (retireValid && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(int'(retirePc) == e.pc, tag, int'(retirePc), e.pc);
        check(regWriteEn == (e.cls == 2'b00), "R9 reg write", int'(regWriteEn), int'(e.cls == 2'b00));
        check(memAccum == ((e.cls == 2'b01) ? 1 : 0), "R9 mem write", memAccum, int'(e.cls == 2'b01));
        if (e.checkCost)
          check(int'(bubbleCount) == e.cost, "R3 R5 bubble count", int'(bubbleCount), e.cost);
        memAccum = 0;
      end
      if (memWriteEn) memAccum++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    clearProg();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(stageValid == 5'b0, "R1 valid flags", int'(stageValid), 0);
    check(fetchPc == '0, "R1 fetch pc", int'(fetchPc), 0);
    check(bubbleCount == '0, "R1 bubble count", int'(bubbleCount), 0);
    check(!memWriteEn && !regWriteEn && !redirect, "R1 strobes", int'({memWriteEn, regWriteEn, redirect}), 0);

    // straight-line code
    runProgram("R2 sequential retire", 1'b0);

    // jumps: 5 -> 20, 22 -> 3
    clearProg();
    setOp(5, 2'b10, 1'b0, 20);
    setOp(22, 2'b10, 1'b0, 3);
    pat[0] = 5'b11101; pat[1] = 5'b11011; pat[2] = 5'b10111; pat[3] = 5'b01111;
    runProgram("R3 jump retire", 1'b1);

    // conditional: 4 taken -> 30, 31 not taken, 33 taken -> 2
    clearProg();
    setOp(4, 2'b11, 1'b1, 30);
    setOp(31, 2'b11, 1'b0, 9);
    setOp(33, 2'b11, 1'b1, 2);
    pat[0] = 5'b11001; pat[1] = 5'b10011; pat[2] = 5'b00111; pat[3] = 5'b01111;
    runProgram("R5 R6 branch retire", 1'b1);

    // R7: taken branch at 6 with jump at 7; R8: jump at 44 behind jump at 43
    clearProg();
    setOp(6, 2'b11, 1'b1, 40);
    setOp(7, 2'b10, 1'b0, 60);
    setOp(43, 2'b10, 1'b0, 50);
    setOp(44, 2'b10, 1'b0, 90);
    setOp(50, 2'b10, 1'b0, 0);
    runProgram("R7 R8 priority retire", 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule